// File: doc/BRIEF.md
# Fault-Injecting Serial Character Transmitter

This block is a stimulus source for checking an asynchronous serial receiver. It sends start/data/parity/stop characters on one output line. The character length, the parity mode, the stop length and an optional trailing break are all set on the configuration inputs. A send request asks for a run of characters. The run either repeats one supplied byte or draws each byte from an internal pseudo-random generator. The busy flag stays high until the whole run has gone out.

The block can also break the rules on purpose, so that a receiver's error handling can be tested. It can invert the parity bit, pull the stop bit low, flip the line for a single clock at a programmed clock offset from the first start edge, and hold the line low for a programmed number of bit periods after every character. A divisor input sets the rate of a tick, and every bit lasts 16 ticks.

Top module: `uart_fault_tx`

## Requirements
- R1: After reset `txd_o` is high and `busy_o` is low. While idle the line stays high.
- R2: A character starts with a low start bit. The data bits follow, least significant first. `cfg_nbits_i` gives the number of data bits: values 5 to 8 are used as given, a value below 5 acts as 5 and a value above 8 acts as 8. Each bit lasts 16 ticks, and one tick lasts `div_i` clocks (a divisor of 0 behaves as 1). The line follows the accepting clock edge with no delay.
- R3: `cfg_par_i` selects the parity bit that follows the data bits. The codes are 0 for none, 1 for odd, 2 for even, 3 for a constant 1 and 4 for a constant 0. Codes 5 to 7 mean no parity bit.
- R4: With `cfg_xstop_i` low the stop level lasts one bit. With it high, the stop level lasts 1.5 bits (24 ticks) for 5-bit characters and 2 bits for every other length.
- R5: With `cfg_badpar_i` high the parity bit is the inverse of the correct value for the selected mode.
- R6: With `cfg_badstop_i` high the stop interval is driven low instead of high.
- R7: A nonzero `cfg_glitch_i` value N inverts `txd_o` for exactly one clock. That clock is clock N after the edge that starts the first character of a request. It happens once per request, and a value of 0 disables it.
- R8: With `cfg_brk_en_i` high and a nonzero `cfg_brk_len_i`, every character is followed by a low break of `cfg_brk_len_i` bit periods.
- R9: With `snd_random_i` set, `snd_byte_i` is ignored. Each character's data is the low bits of a 16-bit shift register with feedback x^16+x^14+x^13+x^11+1, which is seeded with 0xACE1 at reset and steps once for each random character.
- R10: A request with a count of C sends C characters back to back. `busy_o` falls at the clock edge that ends the last character. A count of 0 is ignored, and so is any request made while busy.
- R11: The configuration inputs are sampled only when a character starts. A change made during a character applies from the next character onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Clocks per tick (0 acts as 1) |
| cfg_nbits_i | input | 4 | Data bits per character |
| cfg_par_i | input | 3 | Parity mode code |
| cfg_xstop_i | input | 1 | Extra stop length select |
| cfg_badpar_i | input | 1 | Invert the parity bit |
| cfg_badstop_i | input | 1 | Drive the stop interval low |
| cfg_glitch_i | input | GLITCH_W | Glitch offset in clocks, 0 = off |
| cfg_brk_en_i | input | 1 | Append a break after each character |
| cfg_brk_len_i | input | 16 | Break length in bit periods |
| snd_valid_i | input | 1 | Send request |
| snd_random_i | input | 1 | Use pseudo-random data |
| snd_byte_i | input | 8 | Data byte for non-random sends |
| snd_count_i | input | CNT_W | Number of characters |
| busy_o | output | 1 | Run in progress |
| txd_o | output | 1 | Serial line |

## Verification
The functions that can fall in the same cycle are a configuration or send-request change and a character in flight. The bench provokes this by shortening the character length and raising a new random request partway through the first character of a two-character run. It judges the result by checking three things: the first character keeps all eight data bits, the second has five, and `busy_o` falls exactly where two characters end, with no extra character after them. The glitch pulse is tested separately. It is placed inside the start bit of the first character, and the bench checks that the same offset in the second character stays clean.

// File: rtl/uft_pkg.sv
package uft_pkg;

   localparam int unsigned TICKS_PER_BIT = 16;
   localparam int unsigned BRK_W         = 16;

   typedef enum logic [2:0] {
      PAR_NONE = 3'd0,
      PAR_ODD  = 3'd1,
      PAR_EVEN = 3'd2,
      PAR_ONE  = 3'd3,
      PAR_ZERO = 3'd4
   } par_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
   } st_e;

   // Snapshot of everything one character needs, frozen at its start
   typedef struct packed {
      logic [3:0]       nbits;
      logic             par_en;
      logic             par_bit;
      logic             xstop;
      logic             bad_stop;
      logic             brk_en;
      logic [BRK_W-1:0] brk_len;
   } chr_t;

   function automatic logic [3:0] fit_len(input logic [3:0] l);
      if (l < 4'd5) return 4'd5;
      if (l > 4'd8) return 4'd8;
      return l;
   endfunction

   function automatic logic [7:0] len_mask(input logic [3:0] l);
      return 8'hFF >> (4'd8 - l);
   endfunction

   // Returns {enable, bit}
   function automatic logic [1:0] par_calc(input logic [2:0] mode,
                                           input logic [7:0] d,
                                           input logic flip);
      case (mode)
         PAR_ODD:  return {1'b1, ~(^d) ^ flip};
         PAR_EVEN: return {1'b1, (^d) ^ flip};
         PAR_ONE:  return {1'b1, ~flip};
         PAR_ZERO: return {1'b1, flip};
         default:  return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/uft_tick_gen.sv
module uft_tick_gen #(
   parameter int unsigned DIV_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   generate
      if (DIV_W < 1) begin : g_bad_w
         $error("uft_tick_gen: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;

   assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
   assign tick_o = (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clr_i || tick_o)  cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   // R2: with a divisor above one, ticks never come on adjacent clocks
   p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !clr_i && lim != '0) |=> (!tick_o || !$stable(div_i) || $past(clr_i)));

endmodule

// File: rtl/uft_lfsr.sv
module uft_lfsr #(
   parameter int unsigned   W    = 16,
   parameter logic [W-1:0]  SEED = 'hACE1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   output logic [W-1:0] state_o
);

   logic [W-1:0] taps;

   generate
      if (W == 16) begin : g_w16
         assign taps = W'(16'hB400);
      end else if (W == 8) begin : g_w8
         assign taps = W'(8'hB8);
      end else begin : g_bad_w
         $error("uft_lfsr: only widths 8 and 16 are supported");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("uft_lfsr: SEED must be nonzero");
      end
   endgenerate

   logic [W-1:0] st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_q <= SEED;
      else if (step_i)  st_q <= {st_q[W-2:0], ^(st_q & taps)};
   end

   assign state_o = st_q;

   // R9: the generator never locks up in the all-zero state
   p_lfsr_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != '0);

endmodule

// File: rtl/uft_glitch.sv
module uft_glitch #(
   parameter int unsigned W = 24
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         arm_i,
   input  logic         run_i,
   input  logic [W-1:0] dly_i,
   output logic         pulse_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("uft_glitch: W must be at least 1");
      end
   endgenerate

   logic         armed_q, pulse_q;
   logic [W-1:0] cnt_q, dly_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         pulse_q <= 1'b0;
         cnt_q   <= '0;
         dly_q   <= '0;
      end else begin
         pulse_q <= 1'b0;
         if (!run_i) begin
            armed_q <= 1'b0;
         end else if (arm_i) begin
            armed_q <= (dly_i != '0);
            dly_q   <= dly_i;
            cnt_q   <= W'(1);
         end else if (armed_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == dly_q) begin
               pulse_q <= 1'b1;
               armed_q <= 1'b0;
            end
         end
      end
   end

   assign pulse_o = pulse_q;

   // R7: a glitch lasts one clock
   p_glitch_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

endmodule

// File: rtl/uart_fault_tx.sv
module uart_fault_tx
   import uft_pkg::*;
#(
   parameter int unsigned          DIV_W     = 16,
   parameter int unsigned          GLITCH_W  = 24,
   parameter int unsigned          CNT_W     = 32,
   parameter int unsigned          LFSR_W    = 16,
   parameter logic [LFSR_W-1:0]    LFSR_SEED = 'hACE1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DIV_W-1:0]    div_i,
   input  logic [3:0]          cfg_nbits_i,
   input  logic [2:0]          cfg_par_i,
   input  logic                cfg_xstop_i,
   input  logic                cfg_badpar_i,
   input  logic                cfg_badstop_i,
   input  logic [GLITCH_W-1:0] cfg_glitch_i,
   input  logic                cfg_brk_en_i,
   input  logic [BRK_W-1:0]    cfg_brk_len_i,
   input  logic                snd_valid_i,
   input  logic                snd_random_i,
   input  logic [7:0]          snd_byte_i,
   input  logic [CNT_W-1:0]    snd_count_i,
   output logic                busy_o,
   output logic                txd_o
);

   localparam int unsigned SLOT_W = BRK_W + 4;

   generate
      if (LFSR_W < 8) begin : g_bad_lfsr
         $error("uart_fault_tx: LFSR_W must cover a full byte");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("uart_fault_tx: CNT_W must be at least 1");
      end
   endgenerate

   st_e                st_q, st_d;
   chr_t               cfg_q, cfg_d;
   logic [7:0]         dat_q, byte_q, src_byte, src_data;
   logic               rnd_q, use_rnd;
   logic [3:0]         bitn_q, nb_in;
   logic [1:0]         par_in;
   logic [SLOT_W-1:0]  tcnt_q, slot_len;
   logic [CNT_W-1:0]   left_q;
   logic               tick, slot_end, last_char, brk_on;
   logic               accept, new_char, glitch, lvl;
   logic [LFSR_W-1:0]  lfsr;

   uft_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (st_q == ST_IDLE),
      .div_i  (div_i),
      .tick_o (tick)
   );

   assign brk_on    = cfg_q.brk_en && (cfg_q.brk_len != '0);
   assign last_char = (left_q == CNT_W'(1));

   always_comb begin
      case (st_q)
         ST_STOP: slot_len = cfg_q.xstop ? ((cfg_q.nbits == 4'd5) ? SLOT_W'(24) : SLOT_W'(32))
                                         : SLOT_W'(TICKS_PER_BIT);
         ST_BRK:  slot_len = {cfg_q.brk_len, 4'b0000};
         default: slot_len = SLOT_W'(TICKS_PER_BIT);
      endcase
   end

   assign slot_end = tick && (st_q != ST_IDLE) && (tcnt_q == slot_len - 1'b1);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (snd_valid_i && snd_count_i != '0) st_d = ST_START;
         ST_START: if (slot_end) st_d = ST_DATA;
         ST_DATA:  if (slot_end && bitn_q == cfg_q.nbits - 4'd1)
                      st_d = cfg_q.par_en ? ST_PAR : ST_STOP;
         ST_PAR:   if (slot_end) st_d = ST_STOP;
         ST_STOP:  if (slot_end) st_d = brk_on ? ST_BRK : (last_char ? ST_IDLE : ST_START);
         ST_BRK:   if (slot_end) st_d = last_char ? ST_IDLE : ST_START;
         default:  st_d = ST_IDLE;
      endcase
   end

   assign accept   = (st_q == ST_IDLE)  && (st_d == ST_START);
   assign new_char = (st_q != ST_START) && (st_d == ST_START);

   // Character source and configuration snapshot
   assign use_rnd  = accept ? snd_random_i : rnd_q;
   assign src_byte = use_rnd ? lfsr[7:0] : (accept ? snd_byte_i : byte_q);
   assign nb_in    = fit_len(cfg_nbits_i);
   assign src_data = src_byte & len_mask(nb_in);
   assign par_in   = par_calc(cfg_par_i, src_data, cfg_badpar_i);

   always_comb begin
      cfg_d.nbits    = nb_in;
      cfg_d.par_en   = par_in[1];
      cfg_d.par_bit  = par_in[0];
      cfg_d.xstop    = cfg_xstop_i;
      cfg_d.bad_stop = cfg_badstop_i;
      cfg_d.brk_en   = cfg_brk_en_i;
      cfg_d.brk_len  = cfg_brk_len_i;
   end

   uft_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (new_char && use_rnd),
      .state_o (lfsr)
   );

   uft_glitch #(.W(GLITCH_W)) u_glitch (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_i   (accept),
      .run_i   (st_d != ST_IDLE),
      .dly_i   (cfg_glitch_i),
      .pulse_o (glitch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cfg_q  <= '0;
         dat_q  <= '0;
         byte_q <= '0;
         rnd_q  <= 1'b0;
         bitn_q <= '0;
         tcnt_q <= '0;
         left_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            rnd_q  <= snd_random_i;
            byte_q <= snd_byte_i;
            left_q <= snd_count_i;
         end else if (new_char) begin
            left_q <= left_q - 1'b1;
         end
         if (new_char) begin
            cfg_q  <= cfg_d;
            dat_q  <= src_data;
            bitn_q <= '0;
         end else if (st_q == ST_DATA && slot_end) begin
            bitn_q <= bitn_q + 4'd1;
         end
         if (slot_end || st_q == ST_IDLE) tcnt_q <= '0;
         else if (tick)                   tcnt_q <= tcnt_q + 1'b1;
      end
   end

   always_comb begin
      case (st_q)
         ST_START: lvl = 1'b0;
         ST_DATA:  lvl = dat_q[bitn_q[2:0]];
         ST_PAR:   lvl = cfg_q.par_bit;
         ST_STOP:  lvl = ~cfg_q.bad_stop;
         ST_BRK:   lvl = 1'b0;
         default:  lvl = 1'b1;
      endcase
   end

   assign txd_o  = lvl ^ glitch;
   assign busy_o = (st_q != ST_IDLE);

   // R1: idle line is high
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> txd_o);

   // R2: the first busy cycle shows the start level
   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !txd_o);

   // R8: break interval is low unless a glitch is on the line
   p_break_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BRK && !glitch) |-> !txd_o);

   // R6: stop interval level follows the frozen fault flag
   p_stop_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_STOP && !glitch) |-> (txd_o == !cfg_q.bad_stop));

   // R11: configuration is frozen while data or parity is on the line
   p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA || st_q == ST_PAR) |=> $stable(cfg_q));

endmodule

// File: tb/test_uart_fault_tx.sv
module test_uart_fault_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] div;
   logic [3:0]  nbits;
   logic [2:0]  par;
   logic        xstop, badpar, badstop, brk_en;
   logic [23:0] glitch_n;
   logic [15:0] brk_len;
   logic        snd_valid, snd_random;
   logic [7:0]  snd_byte;
   logic [31:0] snd_count;
   logic        busy, txd;

   int          total = 0;
   int          bad = 0;
   logic [511:0] exp_v, act_v;
   int          exp_n;
   logic [15:0] lf_m = 16'hACE1;
   int          dv = 2;

   always #2 clk = ~clk;

   uart_fault_tx i_uart_fault_tx (
      .clk           (clk),
      .rst_n         (rst_n),
      .div_i         (div),
      .cfg_nbits_i   (nbits),
      .cfg_par_i     (par),
      .cfg_xstop_i   (xstop),
      .cfg_badpar_i  (badpar),
      .cfg_badstop_i (badstop),
      .cfg_glitch_i  (glitch_n),
      .cfg_brk_en_i  (brk_en),
      .cfg_brk_len_i (brk_len),
      .snd_valid_i   (snd_valid),
      .snd_random_i  (snd_random),
      .snd_byte_i    (snd_byte),
      .snd_count_i   (snd_count),
      .busy_o        (busy),
      .txd_o         (txd)
   );

   // {len[3:0], parity[2:0], xstop, badpar, badstop, data[7:0]}
   localparam logic [17:0] VEC [8] = '{
      {4'd8, 3'd0, 1'b0, 1'b0, 1'b0, 8'hA5},
      {4'd7, 3'd1, 1'b0, 1'b0, 1'b0, 8'h3C},
      {4'd6, 3'd2, 1'b1, 1'b0, 1'b0, 8'h2D},
      {4'd5, 3'd3, 1'b1, 1'b0, 1'b0, 8'h13},
      {4'd5, 3'd4, 1'b0, 1'b0, 1'b0, 8'h0E},
      {4'd8, 3'd2, 1'b0, 1'b1, 1'b0, 8'h81},
      {4'd8, 3'd1, 1'b0, 1'b0, 1'b1, 8'h7F},
      {4'd6, 3'd1, 1'b1, 1'b1, 1'b1, 8'h15}
   };
   string tg [8] = '{"R2", "R3", "R4", "R4", "R3", "R5", "R6", "R5"};

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic clear_exp();
      exp_v = '0;
      exp_n = 0;
   endtask

   task automatic add_half(input logic v);
      exp_v[exp_n] = v;
      exp_n++;
   endtask

   task automatic add_char(input int len, input int pm, input bit xs, input bit bp,
                           input bit bs, input bit be, input int bl, input logic [7:0] d);
      logic [7:0] m;
      logic       p;
      m = d & (8'hFF >> (8 - len));
      repeat (2) add_half(1'b0);
      for (int i = 0; i < len; i++) repeat (2) add_half(m[i]);
      if (pm >= 1 && pm <= 4) begin
         case (pm)
            1:       p = ~(^m);
            2:       p = ^m;
            3:       p = 1'b1;
            default: p = 1'b0;
         endcase
         repeat (2) add_half(p ^ bp);
      end
      repeat (xs ? ((len == 5) ? 3 : 4) : 2) add_half(~bs);
      if (be && bl > 0) repeat (2 * bl) add_half(1'b0);
   endtask

   task automatic start_send(input bit r, input logic [7:0] b, input logic [31:0] c);
      @(negedge clk);
      snd_valid  = 1'b1;
      snd_random = r;
      snd_byte   = b;
      snd_count  = c;
      @(negedge clk);
      snd_valid  = 1'b0;
   endtask

   // Call right after start_send: current negedge is cycle 0 of the run
   task automatic capture(input string tag, input int chg_h);
      int cur;
      int tgt;
      int tot;
      int first;
      cur = 0;
      first = -1;
      act_v = '0;
      for (int h = 0; h < exp_n; h++) begin
         tgt = h * 8 * dv + 4 * dv;
         repeat (tgt - cur) @(negedge clk);
         cur = tgt;
         act_v[h] = txd;
         if (h == chg_h) begin
            nbits = 4'd5;
            snd_valid = 1'b1;
            snd_random = 1'b1;
            snd_byte = 8'hFF;
            snd_count = 32'd7;
         end
         if (h == chg_h + 1) snd_valid = 1'b0;
      end
      tot = exp_n * 8 * dv;
      repeat (tot - 1 - cur) @(negedge clk);
      chk(busy === 1'b1, {tag, " busy held to final clock"}, 32'(busy), 32'd1);
      @(negedge clk);
      chk(busy === 1'b0 && txd === 1'b1, {tag, " idle after run"}, {30'd0, busy, txd}, 32'd1);
      for (int h = 0; h < exp_n; h++)
         if (act_v[h] !== exp_v[h] && first < 0) first = h;
      chk(first < 0, $sformatf("%s line level at half-bit %0d", tag, first),
          (first < 0) ? 32'd0 : 32'(act_v[first]),
          (first < 0) ? 32'd0 : 32'(exp_v[first]));
   endtask

   task automatic set_cfg(input logic [17:0] v);
      nbits   = v[17:14];
      par     = v[13:11];
      xstop   = v[10];
      badpar  = v[9];
      badstop = v[8];
   endtask

   initial begin
      div = 16'd2; nbits = 4'd8; par = 3'd0; xstop = 1'b0; badpar = 1'b0; badstop = 1'b0;
      glitch_n = '0; brk_en = 1'b0; brk_len = '0;
      snd_valid = 1'b0; snd_random = 1'b0; snd_byte = '0; snd_count = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(busy === 1'b0 && txd === 1'b1, "R1 reset state", {30'd0, busy, txd}, 32'd1);

      // Table of framing / fault vectors
      for (int k = 0; k < 8; k++) begin
         set_cfg(VEC[k]);
         clear_exp();
         add_char(int'(VEC[k][17:14]), int'(VEC[k][13:11]), VEC[k][10], VEC[k][9], VEC[k][8],
                  1'b0, 0, VEC[k][7:0]);
         start_send(1'b0, VEC[k][7:0], 32'd1);
         capture(tg[k], -1);
      end
      badpar = 1'b0; badstop = 1'b0; xstop = 1'b0;

      // R2: different divisor gives a proportionally longer bit
      dv = 3; div = 16'd3;
      set_cfg(VEC[0]);
      clear_exp();
      add_char(8, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 8'hC6);
      start_send(1'b0, 8'hC6, 32'd1);
      capture("R2 divisor 3", -1);
      dv = 2; div = 16'd2;

      // R8: break after the character
      nbits = 4'd5; par = 3'd0; brk_en = 1'b1; brk_len = 16'd2;
      clear_exp();
      add_char(5, 0, 1'b0, 1'b0, 1'b0, 1'b1, 2, 8'h0B);
      start_send(1'b0, 8'h0B, 32'd1);
      capture("R8 break", -1);
      brk_en = 1'b0; brk_len = '0;

      // R9: random burst, supplied byte ignored
      nbits = 4'd8; par = 3'd2;
      clear_exp();
      for (int i = 0; i < 3; i++) begin
         add_char(8, 2, 1'b0, 1'b0, 1'b0, 1'b0, 0, lf_m[7:0]);
         lf_m = {lf_m[14:0], lf_m[15] ^ lf_m[13] ^ lf_m[12] ^ lf_m[10]};
      end
      start_send(1'b1, 8'hFF, 32'd3);
      capture("R9 random burst", -1);

      // R11 / R10: change length and raise a request mid-character
      nbits = 4'd8; par = 3'd0;
      clear_exp();
      add_char(8, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 8'h5A);
      add_char(5, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 8'h5A);
      start_send(1'b0, 8'h5A, 32'd2);
      capture("R11 config at next character, R10 request while busy ignored", 4);

      // R7: one-shot glitch 5 clocks after the first start edge
      nbits = 4'd5; par = 3'd0; glitch_n = 24'd5;
      start_send(1'b0, 8'h00, 32'd2);
      repeat (4) @(negedge clk);
      chk(txd === 1'b0, "R7 cycle before glitch", 32'(txd), 32'd0);
      @(negedge clk);
      chk(txd === 1'b1, "R7 glitch cycle", 32'(txd), 32'd1);
      @(negedge clk);
      chk(txd === 1'b0, "R7 cycle after glitch", 32'(txd), 32'd0);
      repeat (223) @(negedge clk);
      chk(txd === 1'b0, "R7 no repeat in second character", 32'(txd), 32'd0);
      repeat (219) @(negedge clk);
      chk(busy === 1'b0, "R7 run length two characters", 32'(busy), 32'd0);
      glitch_n = '0;

      // R10: zero count ignored
      start_send(1'b0, 8'h55, 32'd0);
      chk(busy === 1'b0 && txd === 1'b1, "R10 zero count ignored", {30'd0, busy, txd}, 32'd1);
      repeat (10) @(negedge clk);
      chk(busy === 1'b0 && txd === 1'b1, "R10 still idle", {30'd0, busy, txd}, 32'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule